// File: doc/BRIEF.md
# Lockable Serial Number Store

This block holds an eight-byte identification value that software may program and reprogram through a byte-wide register port. Each byte has its own address. A separate seal flag in a control register turns the store read-only. Once software sets the flag, later writes to the eight bytes complete on the bus but change nothing. No register write can clear the flag again. Reads of the bytes and of the flag are allowed at all times. Only the power-on reset input clears the flag, and it stands for a fresh device. In this model the nonvolatile storage is built from flops, so a power-on reset also returns every byte to zero.

The seal logic is a two-state machine. In state `ST_OPEN`, byte writes are accepted. In state `ST_SEALED`, they are suppressed. The only transition is `SEAL`. It moves from `ST_OPEN` to `ST_SEALED` when a write to the control register carries a 1 in bit 7. Every other event holds the current state. `ST_SEALED` has no way out except power-on reset. Read data is combinational from the stored state, so in a write cycle it shows the value held before that cycle's clock edge.

Top module: `sn_store`

## Requirements
- R1: After power-on reset (`por_n` low), all eight bytes read 00h, the control register at address 0Bh reads 00h, and the seal state is `ST_OPEN`.
- R2: While unsealed, a write to address 11h+i (i = 0..7) stores the write data in byte i at the clock edge. A later read of that address returns it.
- R3: While unsealed, a byte can be rewritten any number of times, and each read returns the most recent value written.
- R4: A write to address 0Bh with bit 7 = 1 takes transition `SEAL`. From the next cycle on, address 0Bh reads 80h.
- R5: A write to address 0Bh with bit 7 = 0 leaves the seal state unchanged. Bits 6..0 of 0Bh are never stored and always read 0.
- R6: While sealed, a write to any of addresses 11h..18h completes without error and leaves every byte unchanged.
- R7: While sealed, no write to 0Bh, whatever its data, returns the block to `ST_OPEN`. Address 0Bh keeps reading 80h.
- R8: After sealing, every byte still reads back the value it held when the seal was set.
- R9: Reads of any address other than 0Bh and 11h..18h return 00h. Writes to such addresses change neither the bytes nor the seal.
- R10: During a cycle that writes an address, the read data for that address shows the contents from before the write. The new contents appear from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register port clock |
| por_n | input | 1 | Active-low power-on reset; clears bytes and seal |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle while high |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |

## Verification
A read and a write of the same location share a cycle whenever the strobe is high, because the read port always follows the address. Every write the bench applies is therefore also judged as a read. The data seen before the edge must equal the reference model's old contents, and the next access must see the new ones. The seal write and the read of the seal flag also coincide. The bench sets the seal and checks 00h in that same cycle and 80h in the next. It then sends byte writes right after the seal, so that suppression must take effect with no lag.

// File: rtl/sn_pkg.sv
package sn_pkg;

    localparam int SN_BYTES   = 8;
    localparam int SN_ADDR_W  = 8;
    localparam int SN_DATA_W  = 8;

    // seal state machine encoding
    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_SEALED = 1'b1
    } seal_state_t;

endpackage

// File: rtl/sn_addr_dec.sv
module sn_addr_dec #(
    parameter int                    BYTES     = sn_pkg::SN_BYTES,
    parameter int                    ADDR_W    = sn_pkg::SN_ADDR_W,
    parameter logic [ADDR_W-1:0]     BASE_ADDR = 8'h11,
    parameter logic [ADDR_W-1:0]     CTRL_ADDR = 8'h0B
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [BYTES-1:0]  byte_sel_o,
    output logic              ctrl_sel_o
);

    // one compare per byte slot
    for (genvar gi = 0; gi < BYTES; gi++) begin : g_sel
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE_ADDR + gi);
        assign byte_sel_o[gi] = (addr_i == SLOT_ADDR);
    end

    assign ctrl_sel_o = (addr_i == CTRL_ADDR);

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({byte_sel_o, ctrl_sel_o})); // R2

endmodule

// File: rtl/sn_seal_fsm.sv
module sn_seal_fsm #(
    parameter int DATA_W   = sn_pkg::SN_DATA_W,
    parameter int SEAL_BIT = 7
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_i,
    input  logic              ctrl_sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              sealed_o
);
    import sn_pkg::*;

    seal_state_t state_q, state_d;
    logic        seal_req;

    assign seal_req = wr_i && ctrl_sel_i && wdata_i[SEAL_BIT];

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // next state: SEAL is the only transition
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (seal_req) state_d = ST_SEALED;
            ST_SEALED: state_d = ST_SEALED;
            default:   state_d = ST_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        sealed_o = 1'b0;
        unique case (state_q)
            ST_OPEN:   sealed_o = 1'b0;
            ST_SEALED: sealed_o = 1'b1;
            default:   sealed_o = 1'b0;
        endcase
    end

    AST_SEAL_TAKES: assert property (@(posedge clk) disable iff (!por_n)
        (wr_i && ctrl_sel_i && wdata_i[SEAL_BIT]) |=> sealed_o); // R4

    AST_SEAL_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        sealed_o |=> sealed_o); // R7

    AST_CLEAR_BIT_NO_EFFECT: assert property (@(posedge clk) disable iff (!por_n)
        (!sealed_o && !(wr_i && ctrl_sel_i && wdata_i[SEAL_BIT])) |=> !sealed_o); // R5

endmodule

// File: rtl/sn_byte_bank.sv
module sn_byte_bank #(
    parameter int BYTES  = sn_pkg::SN_BYTES,
    parameter int DATA_W = sn_pkg::SN_DATA_W
) (
    input  logic                         clk,
    input  logic                         por_n,
    input  logic                         wr_i,
    input  logic [BYTES-1:0]             byte_sel_i,
    input  logic                         sealed_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [BYTES-1:0][DATA_W-1:0] bytes_o
);

    logic [BYTES-1:0][DATA_W-1:0] mem_q;

    for (genvar gi = 0; gi < BYTES; gi++) begin : g_byte
        logic wr_ok;
        assign wr_ok = wr_i && byte_sel_i[gi] && !sealed_i;

        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)     mem_q[gi] <= '0;
            else if (wr_ok) mem_q[gi] <= wdata_i;
        end

        AST_BYTE_WRITE: assert property (@(posedge clk) disable iff (!por_n)
            (wr_i && byte_sel_i[gi] && !sealed_i) |=> (mem_q[gi] == $past(wdata_i))); // R2
    end

    assign bytes_o = mem_q;

    AST_NO_WRITE_SEALED: assert property (@(posedge clk) disable iff (!por_n)
        sealed_i |=> $stable(mem_q)); // R6

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!por_n)
        !(wr_i && |byte_sel_i) |=> $stable(mem_q)); // R9

endmodule

// File: rtl/sn_store.sv
module sn_store #(
    parameter int                   BYTES     = sn_pkg::SN_BYTES,
    parameter int                   ADDR_W    = sn_pkg::SN_ADDR_W,
    parameter int                   DATA_W    = sn_pkg::SN_DATA_W,
    parameter logic [ADDR_W-1:0]    BASE_ADDR = 8'h11,
    parameter logic [ADDR_W-1:0]    CTRL_ADDR = 8'h0B,
    parameter int                   SEAL_BIT  = 7
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata
);

    logic [BYTES-1:0]             byte_sel;
    logic                         ctrl_sel;
    logic                         sealed;
    logic [BYTES-1:0][DATA_W-1:0] bytes;
    logic [DATA_W-1:0]            ctrl_view;

    sn_addr_dec #(
        .BYTES    (BYTES),
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .clk       (clk),
        .por_n     (por_n),
        .addr_i    (reg_addr),
        .byte_sel_o(byte_sel),
        .ctrl_sel_o(ctrl_sel)
    );

    sn_seal_fsm #(
        .DATA_W  (DATA_W),
        .SEAL_BIT(SEAL_BIT)
    ) u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .wr_i      (reg_we),
        .ctrl_sel_i(ctrl_sel),
        .wdata_i   (reg_wdata),
        .sealed_o  (sealed)
    );

    sn_byte_bank #(
        .BYTES (BYTES),
        .DATA_W(DATA_W)
    ) u_bank (
        .clk       (clk),
        .por_n     (por_n),
        .wr_i      (reg_we),
        .byte_sel_i(byte_sel),
        .sealed_i  (sealed),
        .wdata_i   (reg_wdata),
        .bytes_o   (bytes)
    );

    // control register view: only the seal flag is implemented
    always_comb begin
        ctrl_view           = '0;
        ctrl_view[SEAL_BIT] = sealed;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (ctrl_sel) reg_rdata = ctrl_view;
        for (int i = 0; i < BYTES; i++) begin
            if (byte_sel[i]) reg_rdata = bytes[i];
        end
    end

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        (!ctrl_sel && byte_sel == '0) |-> (reg_rdata == '0)); // R9

    AST_CTRL_LOW_BITS: assert property (@(posedge clk) disable iff (!por_n)
        ctrl_sel |-> ((reg_rdata & ~(DATA_W'(1) << SEAL_BIT)) == '0)); // R5

endmodule

// File: tb/test_sn_store.sv
module test_sn_store;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    // behavioural reference model
    logic [7:0] ref_mem [8];
    bit         ref_seal;

    always #5 clk = ~clk;

    sn_store i_sn_store (
        .clk      (clk),
        .por_n    (por_n),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] ref_read(input logic [7:0] a);
        if (a == 8'h0B) return {ref_seal, 7'b0};
        if (a >= 8'h11 && a <= 8'h18) return ref_mem[a - 8'h11];
        return 8'h00;
    endfunction

    task automatic ref_reset();
        for (int i = 0; i < 8; i++) ref_mem[i] = 8'h00;
        ref_seal = 1'b0;
    endtask

    task automatic check(input string tag, input logic [7:0] exp);
        vectors++;
        if (reg_rdata !== exp) begin
            miscompares++;
            $display("FAIL %s addr=%02h actual=%02h expected=%02h", tag, reg_addr, reg_rdata, exp);
        end
    endtask

    // one register-port cycle; read data checked before the edge
    task automatic op(input string tag, input logic [7:0] a, input logic [7:0] d, input bit we);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = we;
        #1;
        check(tag, ref_read(a));
        @(posedge clk);
        if (we) begin
            if (a == 8'h0B && d[7]) ref_seal = 1'b1;
            else if (a >= 8'h11 && a <= 8'h18 && !ref_seal) ref_mem[a - 8'h11] = d;
        end
        #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        op(tag, a, 8'h00, 1'b0);
    endtask

    task automatic por();
        @(negedge clk);
        reg_we = 1'b0;
        por_n  = 1'b0;
        ref_reset();
        @(negedge clk);
        por_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            miscompares++;
            $display("FAIL watchdog expired before run completed (R1..)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        ref_reset();
        repeat (3) @(negedge clk);
        por_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 8; i++) rd("R1", 8'(8'h11 + i));
        rd("R1", 8'h0B);

        // R2: program each byte, then read back
        for (int i = 0; i < 8; i++) op("R2", 8'(8'h11 + i), 8'(8'hA0 + 3 * i), 1'b1);
        for (int i = 0; i < 8; i++) rd("R2", 8'(8'h11 + i));

        // R3: repeated rewrites of one byte
        for (int k = 0; k < 6; k++) begin
            op("R3", 8'h14, 8'(k * 37 + 5), 1'b1);
            rd("R3", 8'h14);
        end

        // R5: clear-bit writes to control register
        op("R5", 8'h0B, 8'h7F, 1'b1);
        rd("R5", 8'h0B);
        op("R5", 8'h0B, 8'h00, 1'b1);
        rd("R5", 8'h0B);
        op("R5", 8'h12, 8'h5A, 1'b1);
        rd("R5", 8'h12);

        // R9: unmapped addresses
        op("R9", 8'h10, 8'hFF, 1'b1);
        op("R9", 8'h19, 8'hFF, 1'b1);
        op("R9", 8'h0C, 8'hFF, 1'b1);
        op("R9", 8'h0A, 8'hFF, 1'b1);
        rd("R9", 8'h10);
        rd("R9", 8'h19);
        rd("R9", 8'hFF);
        for (int i = 0; i < 8; i++) rd("R9", 8'(8'h11 + i));
        rd("R9", 8'h0B);

        // R10: write and read of same address in one cycle
        op("R10", 8'h18, 8'hC3, 1'b1);
        rd("R10", 8'h18);
        op("R10", 8'h18, 8'h3C, 1'b1);
        rd("R10", 8'h18);

        // R4: seal; same cycle reads 00, next reads 80
        op("R4", 8'h0B, 8'h80, 1'b1);
        rd("R4", 8'h0B);

        // R6: writes right after seal are suppressed
        for (int i = 0; i < 8; i++) op("R6", 8'(8'h11 + i), 8'(~(8'h11 + i)), 1'b1);
        // R8: contents still readable
        for (int i = 0; i < 8; i++) rd("R8", 8'(8'h11 + i));

        // R7: attempts to clear
        op("R7", 8'h0B, 8'h00, 1'b1);
        rd("R7", 8'h0B);
        op("R7", 8'h0B, 8'h7F, 1'b1);
        rd("R7", 8'h0B);
        op("R7", 8'h0B, 8'hFF, 1'b1);
        rd("R7", 8'h0B);

        // R1: power-on reset as new device, then mixed traffic
        por();
        rd("R1", 8'h0B);
        rd("R1", 8'h15);

        lfsr = 8'h5D;
        for (int n = 0; n < 300; n++) begin
            logic [7:0] a;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (lfsr[2:0])
                3'd0:    a = 8'h0B;
                3'd1:    a = 8'h1A;
                default: a = 8'(8'h11 + lfsr[5:3]);
            endcase
            // seal only late in the run
            if (a == 8'h0B && n < 200) op("R3", a, 8'(lfsr & 8'h7F), lfsr[6]);
            else op(ref_seal ? "R8" : "R2", a, 8'(lfsr ^ 8'h96), lfsr[6]);
        end
        op("R4", 8'h0B, 8'h81, 1'b1);
        for (int i = 0; i < 8; i++) op("R6", 8'(8'h11 + i), 8'h00, 1'b1);
        for (int i = 0; i < 8; i++) rd("R8", 8'(8'h11 + i));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule